// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source layer and one processor. It holds a current processor priority byte, a single slot for an external interrupt offered by the source layer, and a one-byte inter-processor request. It raises `irq_out` whenever the most favoured of the held external source and the inter-processor request beats the current priority. Software reaches it through a small register window of 32-bit words and single bytes.

Reading the pending word is the accept. It returns the priority in force before the read together with the source number of the winning interrupt. As a side effect it raises the current priority to that interrupt's priority. Writing the pending word back is the end of interrupt: the written top byte becomes the new current priority, and the written source number is pulsed to the source layer. An arriving external source that cannot be held, or that is displaced by a more favoured one, is handed back to the source layer for resend.

Top module: `intp_presenter`

## Requirements
- R1: After reset the current priority is 0x00, the inter-processor request byte is 0xFF (no request), the external slot is empty, and `irq_out`, `bus_rvalid`, `src_return` and `eoi_valid` are low.
- R2: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. A word read at offset 0 returns the current priority before the read in bits 31:24 and the winning source number in bits 23:0. A byte read at offset 0 returns the current priority in bits 7:0, and a byte read at offset 4 returns the request byte in bits 7:0. Byte reads never accept. Any other offset reads as 0.
- R3: A word read at offset 0 while `irq_out` is high accepts the interrupt. The current priority becomes the winner's priority, and an accepted external source leaves the slot.
- R4: A word read at offset 0 while `irq_out` is low returns source 0 and changes no state.
- R5: Lower values are more favoured. `irq_out` is high exactly when the winner's priority is strictly below the current priority, so a current priority of 0 blocks everything.
- R6: A word write at offset 0 sets the current priority from `bus_wdata[31:24]`. In the next cycle it pulses `eoi_valid`, with `eoi_src` equal to `bus_wdata[23:0]`.
- R7: A byte write at offset 0 sets the current priority from `bus_wdata[7:0]` and does not pulse `eoi_valid`.
- R8: A byte write at offset 4 (from `bus_wdata[7:0]`), or a word write at offset 4 (from `bus_wdata[31:24]`), sets the request byte. Any value other than 0xFF requests an inter-processor interrupt at that priority with source number `IPI_SRC` (default 2). 0xFF withdraws the request. Accepting the request does not clear it.
- R9: The more favoured of the held external source and the inter-processor request wins. On equal priority the inter-processor request wins.
- R10: An arriving source whose priority is not below the current priority, or not strictly more favoured than an occupied slot's source, is returned: `src_return` pulses in the next cycle with `src_return_id` equal to its number. A more favoured arrival takes the slot, and the displaced source is returned instead.
- R11: A held external source that loses to an accepted inter-processor request stays held and is presented once the priority allows.
- R12: An arrival with source number 0 is ignored: it neither takes the slot nor is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = single byte |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | 32 | Write data; bytes use bits 7:0 |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| src_valid | input | 1 | Source layer offers an interrupt |
| src_id | input | 24 | Offered source number |
| src_prio | input | 8 | Offered priority |
| src_return | output | 1 | Returned source for resend |
| src_return_id | output | 24 | Number of the returned source |
| eoi_valid | output | 1 | End of interrupt pulse |
| eoi_src | output | 24 | Source number being completed |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is the one where the held external source, the inter-processor request and the current priority are all in tension at once. Examples are an equal-priority tie, a held source pushed below an accepted request, or an arrival that displaces a held source in the same cycle an accept empties the slot. Directed sequences build the tie and the displacement step by step. A long random run with addresses weighted toward the pending word, and priorities drawn from a narrow band, keeps arrivals, accepts and end-of-interrupt writes colliding. A cycle model in the bench predicts every output.

// File: rtl/intp_pkg.sv
package intp_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_NONE = '1;
endpackage

// File: rtl/intp_select.sv
module intp_select
    import intp_pkg::*;
#(
    parameter int IPI_SRC = 2
) (
    input  logic  ext_v,
    input  src_t  ext_id,
    input  prio_t ext_prio,
    input  prio_t ipi_prio,
    input  prio_t cppr,
    output logic  present,
    output src_t  win_id,
    output prio_t win_prio,
    output logic  win_ext
);
    logic ipi_req;
    logic pick_ipi;
    logic win_v;

    always_comb begin
        ipi_req  = (ipi_prio != PRIO_NONE);
        // ties go to the inter-processor request (R9)
        pick_ipi = ipi_req && (!ext_v || (ipi_prio <= ext_prio));
        win_v    = pick_ipi || ext_v;
        win_prio = pick_ipi ? ipi_prio : ext_prio;
        win_id   = pick_ipi ? src_t'(IPI_SRC) : ext_id;
        win_ext  = ext_v && !pick_ipi;
        present  = win_v && (win_prio < cppr);
    end

    always_comb begin
        assert_tie_ipi_R9: assert (!(ipi_req && ext_v && (ipi_prio == ext_prio)) || !win_ext);
    end
endmodule

// File: rtl/intp_slot.sv
module intp_slot
    import intp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arr_v,
    input  src_t  arr_id,
    input  prio_t arr_prio,
    input  prio_t cppr,
    input  logic  take_clear,
    output logic  held_v,
    output src_t  held_id,
    output prio_t held_prio,
    output logic  rej_v,
    output src_t  rej_id
);
    typedef struct packed {
        logic  hv;
        src_t  hid;
        prio_t hp;
        logic  rv;
        src_t  rid;
    } slot_t;

    slot_t s_d, s_q;
    logic  kept;

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        kept   = s_q.hv && !take_clear;
        s_d.hv = kept;
        if (arr_v && (arr_id != '0)) begin
            if (arr_prio >= cppr) begin
                s_d.rv  = 1'b1;
                s_d.rid = arr_id;
            end else if (!kept || (arr_prio < s_q.hp)) begin
                if (kept) begin
                    s_d.rv  = 1'b1;
                    s_d.rid = s_q.hid;
                end
                s_d.hv  = 1'b1;
                s_d.hid = arr_id;
                s_d.hp  = arr_prio;
            end else begin
                s_d.rv  = 1'b1;
                s_d.rid = arr_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{hv: 1'b0, hid: '0, hp: PRIO_NONE, rv: 1'b0, rid: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign held_v    = s_q.hv;
    assign held_id   = s_q.hid;
    assign held_prio = s_q.hp;
    assign rej_v     = s_q.rv;
    assign rej_id    = s_q.rid;

    assert_return_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rej_v |-> $past(arr_v));
    assert_zero_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_v && (arr_id == '0) && !take_clear) |=> ($stable(held_v) && !rej_v));
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_clear && !arr_v) |=> !held_v);
endmodule

// File: rtl/intp_presenter.sv
module intp_presenter
    import intp_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int PEND_OFF = 0,
    parameter int IPI_OFF  = 4,
    parameter int IPI_SRC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic              src_valid,
    input  logic [23:0]       src_id,
    input  logic [7:0]        src_prio,
    output logic              src_return,
    output logic [23:0]       src_return_id,
    output logic              eoi_valid,
    output logic [23:0]       eoi_src,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFF);
    localparam logic [ADDR_W-1:0] A_IPI  = ADDR_W'(IPI_OFF);

    typedef struct packed {
        prio_t              cppr;
        prio_t              ipi;
        logic               rvalid;
        logic [WORD_W-1:0]  rdata;
        logic               eoi;
        src_t               eoi_id;
    } regs_t;

    regs_t r_d, r_q;

    logic  held_v;
    src_t  held_id;
    prio_t held_prio;
    logic  present;
    src_t  win_id;
    prio_t win_prio;
    logic  win_ext;
    logic  rd, wr, hit_pend, hit_ipi, accept, take_clear;

    intp_select #(.IPI_SRC(IPI_SRC)) u_sel (
        .ext_v    (held_v),
        .ext_id   (held_id),
        .ext_prio (held_prio),
        .ipi_prio (r_q.ipi),
        .cppr     (r_q.cppr),
        .present  (present),
        .win_id   (win_id),
        .win_prio (win_prio),
        .win_ext  (win_ext)
    );

    intp_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_v      (src_valid),
        .arr_id     (src_id),
        .arr_prio   (src_prio),
        .cppr       (r_q.cppr),
        .take_clear (take_clear),
        .held_v     (held_v),
        .held_id    (held_id),
        .held_prio  (held_prio),
        .rej_v      (src_return),
        .rej_id     (src_return_id)
    );

    always_comb begin
        rd         = bus_valid && !bus_write;
        wr         = bus_valid && bus_write;
        hit_pend   = (bus_addr == A_PEND);
        hit_ipi    = (bus_addr == A_IPI);
        accept     = rd && bus_word && hit_pend && present;
        take_clear = accept && win_ext;

        r_d        = r_q;
        r_d.rvalid = rd;
        r_d.rdata  = '0;
        r_d.eoi    = 1'b0;

        if (rd) begin
            if (hit_pend && bus_word) begin
                r_d.rdata = {r_q.cppr, present ? win_id : src_t'(0)};
            end else if (hit_pend) begin
                r_d.rdata = {{SRC_W{1'b0}}, r_q.cppr};
            end else if (hit_ipi && bus_word) begin
                r_d.rdata = {r_q.ipi, {SRC_W{1'b0}}};
            end else if (hit_ipi) begin
                r_d.rdata = {{SRC_W{1'b0}}, r_q.ipi};
            end
        end

        if (accept) begin
            r_d.cppr = win_prio;
        end

        if (wr && hit_pend) begin
            if (bus_word) begin
                r_d.cppr   = bus_wdata[31:24];
                r_d.eoi    = 1'b1;
                r_d.eoi_id = bus_wdata[23:0];
            end else begin
                r_d.cppr = bus_wdata[7:0];
            end
        end

        if (wr && hit_ipi) begin
            r_d.ipi = bus_word ? bus_wdata[31:24] : bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{cppr: '0, ipi: PRIO_NONE, rvalid: 1'b0, rdata: '0, eoi: 1'b0, eoi_id: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rvalid = r_q.rvalid;
    assign bus_rdata  = r_q.rdata;
    assign eoi_valid  = r_q.eoi;
    assign eoi_src    = r_q.eoi_id;
    assign irq_out    = present;

    assert_accept_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_word && (bus_addr == A_PEND) && irq_out)
        |=> (r_q.cppr == $past(win_prio)));
    assert_zero_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cppr == '0) |-> !irq_out);
    assert_eoi_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_word && (bus_addr == A_PEND))
        |=> (eoi_valid && (eoi_src == $past(bus_wdata[23:0]))));
    assert_byte_no_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_word && (bus_addr == A_PEND)) |=> !eoi_valid);
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
endmodule

// File: tb/tb_intp_presenter.sv
`timescale 1ns/100ps
module tb_intp_presenter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write, bus_word;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        src_valid;
    logic [23:0] src_id;
    logic [7:0]  src_prio;
    logic        src_return;
    logic [23:0] src_return_id;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    logic [7:0]  m_cppr, m_ipi, m_hp;
    logic        m_hv;
    logic [23:0] m_hid;
    logic        e_rvalid, e_rej, e_eoi;
    logic [31:0] e_rdata;
    logic [23:0] e_rejid, e_eoiid;

    always #2.5 clk = ~clk;

    intp_presenter dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .src_valid(src_valid), .src_id(src_id), .src_prio(src_prio),
        .src_return(src_return), .src_return_id(src_return_id),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] m_win();
        // {present, from_ext, prio[7:0], id[23:0]}
        logic pick_ipi, v, pres;
        logic [7:0] p;
        logic [23:0] id;
        pick_ipi = (m_ipi != 8'hFF) && (!m_hv || m_ipi <= m_hp);
        v    = pick_ipi || m_hv;
        p    = pick_ipi ? m_ipi : m_hp;
        id   = pick_ipi ? 24'd2 : m_hid;
        pres = v && (p < m_cppr);
        return {pres, (m_hv && !pick_ipi), p, id};
    endfunction

    task automatic model();
        logic [33:0] w;
        logic acc, kept;
        w = m_win();
        e_rvalid = bus_valid && !bus_write;
        e_rdata  = 32'h0;
        e_eoi    = 1'b0;
        e_rej    = 1'b0;
        if (e_rvalid) begin
            if (bus_addr == 3'd0 && bus_word)      e_rdata = {m_cppr, w[33] ? w[23:0] : 24'h0};
            else if (bus_addr == 3'd0)             e_rdata = {24'h0, m_cppr};
            else if (bus_addr == 3'd4 && bus_word) e_rdata = {m_ipi, 24'h0};
            else if (bus_addr == 3'd4)             e_rdata = {24'h0, m_ipi};
        end
        acc  = e_rvalid && bus_word && bus_addr == 3'd0 && w[33];
        kept = m_hv && !(acc && w[32]);
        // arrival, judged against the priority before this edge
        if (src_valid && src_id != 24'h0) begin
            if (src_prio >= m_cppr) begin
                e_rej = 1'b1; e_rejid = src_id;
            end else if (!kept || src_prio < m_hp) begin
                if (kept) begin e_rej = 1'b1; e_rejid = m_hid; end
                kept = 1'b1; m_hid = src_id; m_hp = src_prio;
            end else begin
                e_rej = 1'b1; e_rejid = src_id;
            end
        end
        m_hv = kept;
        if (acc) m_cppr = w[31:24];
        if (bus_valid && bus_write && bus_addr == 3'd0) begin
            if (bus_word) begin
                m_cppr = bus_wdata[31:24]; e_eoi = 1'b1; e_eoiid = bus_wdata[23:0];
            end else m_cppr = bus_wdata[7:0];
        end
        if (bus_valid && bus_write && bus_addr == 3'd4)
            m_ipi = bus_word ? bus_wdata[31:24] : bus_wdata[7:0];
    endtask

    task automatic step(input logic bv, input logic bw, input logic bword, input logic [2:0] ba,
                        input logic [31:0] wd, input logic sv, input logic [23:0] sid, input logic [7:0] sp);
        logic [33:0] w;
        bus_valid = bv; bus_write = bw; bus_word = bword; bus_addr = ba; bus_wdata = wd;
        src_valid = sv; src_id = sid; src_prio = sp;
        @(posedge clk);
        model();
        @(negedge clk);
        w = m_win();
        chk("R5 irq_out", {31'h0, irq_out}, {31'h0, w[33]});
        chk("R2 rvalid", {31'h0, bus_rvalid}, {31'h0, e_rvalid});
        if (e_rvalid) chk("R2 rdata", bus_rdata, e_rdata);
        chk("R10 src_return", {31'h0, src_return}, {31'h0, e_rej});
        if (e_rej) chk("R10 src_return_id", {8'h0, src_return_id}, {8'h0, e_rejid});
        chk("R6 eoi_valid", {31'h0, eoi_valid}, {31'h0, e_eoi});
        if (e_eoi) chk("R6 eoi_src", {8'h0, eoi_src}, {8'h0, e_eoiid});
    endtask

    task automatic idle();                 step(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rdw(input logic [2:0] a); step(1, 0, 1, a, 0, 0, 0, 0); endtask
    task automatic rdb(input logic [2:0] a); step(1, 0, 0, a, 0, 0, 0, 0); endtask
    task automatic wrw(input logic [2:0] a, input logic [31:0] d); step(1, 1, 1, a, d, 0, 0, 0); endtask
    task automatic wrb(input logic [2:0] a, input logic [7:0] d); step(1, 1, 0, a, {24'h0, d}, 0, 0, 0); endtask
    task automatic offer(input logic [23:0] id, input logic [7:0] p); step(0, 0, 0, 0, 0, 1, id, p); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        bus_valid = 0; bus_write = 0; bus_word = 0; bus_addr = 0; bus_wdata = 0;
        src_valid = 0; src_id = 0; src_prio = 0;
        m_cppr = 8'h00; m_ipi = 8'hFF; m_hv = 1'b0; m_hid = 24'h0; m_hp = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        chk("R1 outputs after reset", {29'h0, bus_rvalid, src_return, eoi_valid}, 32'h0);
        rst_n = 1'b1;
        rdw(0); chk("R1 pending word at reset", bus_rdata, 32'h0000_0000);
        rdb(4); chk("R1 request byte at reset", bus_rdata, 32'h0000_00FF);

        wrb(0, 8'hFF); chk("R7 byte write no eoi", {31'h0, eoi_valid}, 32'h0);
        rdb(0); chk("R7 cppr from byte write", bus_rdata, 32'h0000_00FF);

        offer(24'h0, 8'h03); chk("R12 zero source not returned", {31'h0, src_return}, 32'h0);
        chk("R12 zero source not held", {31'h0, irq_out}, 32'h0);

        offer(24'h123456, 8'h05); chk("R5 present", {31'h0, irq_out}, 32'h1);
        rdw(0); chk("R3 accept read", bus_rdata, 32'hFF12_3456);
        chk("R3 irq drops", {31'h0, irq_out}, 32'h0);
        rdb(0); chk("R3 cppr raised", bus_rdata, 32'h0000_0005);
        rdw(0); chk("R4 empty read", bus_rdata, 32'h0500_0000);
        rdb(0); chk("R4 cppr unchanged", bus_rdata, 32'h0000_0005);
        wrw(0, 32'hFF12_3456); chk("R6 eoi id", {8'h0, eoi_src}, 32'h0012_3456);
        rdb(0); chk("R6 cppr restored", bus_rdata, 32'h0000_00FF);

        wrb(4, 8'h04); chk("R8 request raises irq", {31'h0, irq_out}, 32'h1);
        rdw(0); chk("R8 request source", bus_rdata, 32'hFF00_0002);
        rdb(4); chk("R8 request kept after accept", bus_rdata, 32'h0000_0004);
        wrw(0, 32'hFF00_0002); chk("R8 re-presented", {31'h0, irq_out}, 32'h1);
        wrb(4, 8'hFF); chk("R8 withdrawn", {31'h0, irq_out}, 32'h0);

        offer(24'h000AAA, 8'h04); wrw(4, 32'h0400_0000);
        rdw(0); chk("R9 tie goes to request", bus_rdata, 32'hFF00_0002);
        wrb(4, 8'hFF); wrw(0, 32'hFF00_0002);
        chk("R11 held source presented", {31'h0, irq_out}, 32'h1);
        rdw(0); chk("R11 held source kept", bus_rdata, 32'hFF00_0AAA);
        wrw(0, 32'hFF00_0AAA);

        offer(24'h000BBB, 8'h03); wrb(4, 8'h04);
        rdw(0); chk("R9 favoured source wins", bus_rdata, 32'hFF00_0BBB);
        wrb(4, 8'hFF); wrw(0, 32'h0500_0BBB);

        offer(24'h000C01, 8'h05); chk("R10 not below cppr", {8'h0, src_return_id}, 32'h0000_0C01);
        offer(24'h000C02, 8'h04); offer(24'h000C03, 8'h02);
        chk("R10 displaced returned", {8'h0, src_return_id}, 32'h0000_0C02);
        offer(24'h000C04, 8'h02); chk("R10 equal returned", {8'h0, src_return_id}, 32'h0000_0C04);
        wrb(0, 8'h00); chk("R5 cppr zero blocks", {31'h0, irq_out}, 32'h0);
        wrw(0, 32'hFF00_0000); rdw(0); wrw(0, 32'hFF00_0C03);

        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [7:0] p;
            r = $urandom();
            a = (r[3:0] < 4'd11) ? 3'd0 : ((r[3:0] < 4'd14) ? 3'd4 : 3'd2);
            p = {5'h0, r[6:4]};
            if (r[29:28] == 2'd3) p = 8'hFF;
            step(r[7], r[8], r[9], a, {p, 8'h0, r[23:16], p},
                 r[10] | r[11], {16'h0, r[31:26], 2'b0} | {23'h0, r[12]}, {5'h0, r[15:13]});
        end
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule